// File: doc/BRIEF.md
# Inter-Processor Interrupt Unit

This bus-slave peripheral lets any processor in a small multicore system raise a software interrupt on any chosen processor, including itself. Every interrupt carries a 16-bit tag that says what kind of event it is. Each processor owns two word registers on a Wishbone bus. Writing the control register sends an interrupt. The target index sits in the upper half of the written word and the tag in the lower half. The unit records who sent it and the tag in the target's status register, sets that target's pending flag, and raises its interrupt line.

The pending flag is the interrupt line itself, and any processor may read any status register. A sender that must not overwrite an unserviced interrupt polls the target's status first. The bus never waits: every access is acknowledged in the cycle it is presented. A second send to a target that is still pending replaces the recorded sender and tag. The target services its interrupt by reading its status register and then writing any value to it, which drops the line.

Top module: `ipi_unit`

## Requirements
- R1: After reset every interrupt output is low and every status register reads zero.
- R2: A write to core S's control register (word offset 2S) with destination D (bits 31:16) less than NUM_CORES sets irq_o[D] high from the clock edge that completes the write. No other interrupt output changes.
- R3: After that send, core D's status register (word offset 2D+1) reads bit 31 = pending, bits 30:16 = sender index S, and bits 15:0 = the tag written in bits 15:0.
- R4: wb_ack_o is high in exactly the cycles where wb_cyc_i and wb_stb_i are both high. This holds for every access, including a send to a destination already pending.
- R5: A send to a destination that is already pending overwrites the sender and tag fields. The destination stays pending, and nothing is queued.
- R6: Sends naming different destinations each raise and hold their own interrupt independently.
- R7: Writing any value to core N's status register clears its pending bit and irq_o[N] at the completing edge. The sender and tag fields are kept, and other cores are unaffected.
- R8: A control write whose destination field is NUM_CORES or larger changes no interrupt output and no status register.
- R9: Reading a control register returns zero. No read changes any state; in particular, reading a status register does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Strobe, this slave selected |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | ADDR_W (3) | Word offset: 2N control, 2N+1 status |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Acknowledge, same cycle as strobe |
| irq_o | output | NUM_CORES (4) | Per-core interrupt, equals the pending bit |

## Verification
The assertions rely on the bus presenting at most one access per cycle. Because of that, a send and a clear never target the same core in the same cycle, and the send-over-clear priority is never exercised. They also assume the bus inputs are stable across each clock edge. The bench drives one access at a time, changes inputs only on the falling edge, and follows every access with an idle cycle. It keeps addresses inside the mapped range and puts out-of-range values only in the destination field. The bench keeps its own model of the status registers to predict every read and every interrupt line.

// File: rtl/ipi_pkg.sv
`timescale 1ns/1ps
package ipi_pkg;
  localparam int DATA_W   = 32;
  localparam int TAG_W    = 16;
  localparam int DEST_W   = 16;
  localparam int SENDER_W = 15;

  // status word layout: {pending, sender, tag}
  typedef struct packed {
    logic                pending;
    logic [SENDER_W-1:0] sender;
    logic [TAG_W-1:0]    tag;
  } ipi_status_t;
endpackage

// File: rtl/ipi_decode.sv
`timescale 1ns/1ps
module ipi_decode #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = $clog2(2*NUM_CORES),
  localparam int IDX_W    = ADDR_W - 1
) (
  input  logic                 access_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    adr_i,
  output logic [NUM_CORES-1:0] ctl_we_o,
  output logic [NUM_CORES-1:0] sts_we_o,
  output logic [IDX_W-1:0]     core_idx_o,
  output logic                 is_sts_o,
  output logic                 hit_o
);
  assign core_idx_o = adr_i[ADDR_W-1:1];
  assign is_sts_o   = adr_i[0];
  assign hit_o      = access_i && (int'(core_idx_o) < NUM_CORES);

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_strobe
    assign ctl_we_o[g] = hit_o && we_i && !is_sts_o && (int'(core_idx_o) == g);
    assign sts_we_o[g] = hit_o && we_i &&  is_sts_o && (int'(core_idx_o) == g);
  end
endmodule

// File: rtl/ipi_slot.sv
`timescale 1ns/1ps
module ipi_slot
  import ipi_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                send_i,
  input  logic [SENDER_W-1:0] sender_i,
  input  logic [TAG_W-1:0]    tag_i,
  input  logic                clear_i,
  output ipi_status_t         status_o
);
  ipi_status_t status_q;

  // send wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
    end else if (send_i) begin
      status_q.pending <= 1'b1;
      status_q.sender  <= sender_i;
      status_q.tag     <= tag_i;
    end else if (clear_i) begin
      status_q.pending <= 1'b0;
    end
  end

  assign status_o = status_q;

  assert_send_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_i |=> status_q.pending);
  assert_send_fields_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_i |=> (status_q.tag == $past(tag_i)) && (status_q.sender == $past(sender_i)));
  assert_clear_drops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !send_i) |=> !status_q.pending);
  assert_idle_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!send_i && !clear_i) |=> $stable(status_q));
endmodule

// File: rtl/ipi_rdata.sv
`timescale 1ns/1ps
module ipi_rdata
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int IDX_W     = 2
) (
  input  ipi_status_t [NUM_CORES-1:0] status_i,
  input  logic [IDX_W-1:0]            core_idx_i,
  input  logic                        is_sts_i,
  input  logic                        hit_i,
  output logic [DATA_W-1:0]           rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (hit_i && is_sts_i && (int'(core_idx_i) == i)) rdata_o = status_i[i];
    end
  end
endmodule

// File: rtl/ipi_unit.sv
`timescale 1ns/1ps
module ipi_unit
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = $clog2(2*NUM_CORES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wb_cyc_i,
  input  logic                 wb_stb_i,
  input  logic                 wb_we_i,
  input  logic [ADDR_W-1:0]    wb_adr_i,
  input  logic [DATA_W-1:0]    wb_dat_i,
  output logic [DATA_W-1:0]    wb_dat_o,
  output logic                 wb_ack_o,
  output logic [NUM_CORES-1:0] irq_o
);
  localparam int IDX_W = ADDR_W - 1;

  logic                        access;
  logic [NUM_CORES-1:0]        ctl_we, sts_we, send_hit;
  logic [IDX_W-1:0]            core_idx;
  logic                        is_sts, hit, send_any;
  logic [DEST_W-1:0]           dest;
  logic [SENDER_W-1:0]         sender;
  ipi_status_t [NUM_CORES-1:0] status;

  assign access   = wb_cyc_i && wb_stb_i;
  assign wb_ack_o = access;  // never stalled, never retried

  ipi_decode #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) i_decode (
    .access_i   (access),
    .we_i       (wb_we_i),
    .adr_i      (wb_adr_i),
    .ctl_we_o   (ctl_we),
    .sts_we_o   (sts_we),
    .core_idx_o (core_idx),
    .is_sts_o   (is_sts),
    .hit_o      (hit)
  );

  // sender is implied by which control register was written
  assign send_any = |ctl_we;
  assign dest     = wb_dat_i[DATA_W-1:DATA_W-DEST_W];
  assign sender   = SENDER_W'(core_idx);

  for (genvar d = 0; d < NUM_CORES; d++) begin : g_slot
    assign send_hit[d] = send_any && (32'(dest) == d);

    ipi_slot i_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .send_i   (send_hit[d]),
      .sender_i (sender),
      .tag_i    (wb_dat_i[TAG_W-1:0]),
      .clear_i  (sts_we[d]),
      .status_o (status[d])
    );
    assign irq_o[d] = status[d].pending;
  end

  ipi_rdata #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) i_rdata (
    .status_i   (status),
    .core_idx_i (core_idx),
    .is_sts_i   (is_sts),
    .hit_i      (hit),
    .rdata_o    (wb_dat_o)
  );

  assert_bad_dest_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access && wb_we_i && !wb_adr_i[0] && (32'(dest) >= NUM_CORES)) |=> $stable(irq_o));
  assert_ctl_reads_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access && !wb_we_i && !wb_adr_i[0]) |-> (wb_dat_o == '0));
  assert_irq_tracks_status_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access && !wb_we_i && wb_adr_i[0] && hit) |-> (wb_dat_o[DATA_W-1] == irq_o[core_idx]));
endmodule

// File: tb/test_ipi_unit.sv
`timescale 1ns/1ps
module test_ipi_unit;
  localparam int NC = 4;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          cyc, stb, we;
  logic [AW-1:0] adr;
  logic [31:0]   wdat;
  logic [31:0]   rdat;
  logic          ack;
  logic [NC-1:0] irq;

  always #5 clk = ~clk;

  ipi_unit #(.NUM_CORES(NC)) i_ipi_unit (
    .clk_i(clk), .rst_ni(rst_ni), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack), .irq_o(irq)
  );

  typedef struct { logic [31:0] exp; string req; } item_t;
  item_t q[$];

  int errors = 0;
  int checks = 0;
  bit done = 0;

  bit          m_pend[NC];
  logic [14:0] m_snd[NC];
  logic [15:0] m_tag[NC];

  function automatic logic [31:0] exp_sts(int c);
    return {m_pend[c], m_snd[c], m_tag[c]};
  endfunction

  function automatic logic [NC-1:0] exp_irq();
    logic [NC-1:0] v;
    for (int i = 0; i < NC; i++) v[i] = m_pend[i];
    return v;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic release_bus();
    @(negedge clk);
    cyc = 1'b0; stb = 1'b0; we = 1'b0; adr = '0; wdat = '0;
  endtask

  task automatic send(int src, logic [15:0] dst, logic [15:0] t);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = 1'b1; adr = AW'(2*src); wdat = {dst, t};
    if (int'(dst) < NC) begin
      m_pend[int'(dst)] = 1'b1;
      m_snd[int'(dst)]  = 15'(src);
      m_tag[int'(dst)]  = t;
    end
    release_bus();
  endtask

  task automatic clear(int c, logic [31:0] junk);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = 1'b1; adr = AW'(2*c+1); wdat = junk;
    m_pend[c] = 1'b0;
    release_bus();
  endtask

  task automatic read(int a, logic [31:0] exp, string req);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = AW'(a); wdat = '0;
    q.push_back('{exp: exp, req: req});
    release_bus();
  endtask

  task automatic read_sts(int c, string req);
    read(2*c+1, exp_sts(c), req);
  endtask

  task automatic check_irq(string req);
    @(negedge clk);
    #3;
    check(irq === exp_irq(), req, 32'(irq), 32'(exp_irq()));
  endtask

  // monitor: acknowledge behaviour and read results against the queue
  always @(negedge clk) begin
    #2;
    if (rst_ni && !done) begin
      if (cyc && stb) begin
        check(ack === 1'b1, "R4 ack during access", 32'(ack), 32'd1);
        if (!we) begin
          if (q.size() == 0) begin
            check(1'b0, "R9 unexpected read", rdat, 32'hx);
          end else begin
            item_t it;
            it = q.pop_front();
            check(rdat === it.exp, it.req, rdat, it.exp);
          end
        end
      end else begin
        check(ack === 1'b0, "R4 ack while idle", 32'(ack), 32'd0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired, run hung");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NC; i++) begin m_pend[i] = 0; m_snd[i] = '0; m_tag[i] = '0; end
    rst_ni = 1'b0; cyc = 1'b0; stb = 1'b0; we = 1'b0; adr = '0; wdat = '0;
    repeat (3) @(negedge clk);
    #3 check(irq === '0, "R1 irq in reset", 32'(irq), 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R1: reset state
    check_irq("R1 irq after reset");
    for (int c = 0; c < NC; c++) read_sts(c, "R1 status after reset");

    // R2 / R3: basic send
    send(0, 16'd2, 16'hBEEF);
    check_irq("R2 send 0->2");
    read_sts(2, "R3 status of 2 after send");

    // R5: overwrite while pending
    send(3, 16'd2, 16'h1234);
    check_irq("R5 still pending after overwrite");
    read_sts(2, "R5 overwritten fields");

    // R6: independent destinations
    send(1, 16'd0, 16'h0005);
    send(2, 16'd3, 16'h0007);
    check_irq("R6 three pending");
    read_sts(0, "R6 status of 0");
    read_sts(3, "R6 status of 3");
    read_sts(1, "R6 core 1 untouched");

    // R9: reads have no side effect, control reads zero
    read_sts(2, "R9 repeat read 1");
    read_sts(2, "R9 repeat read 2");
    check_irq("R9 reads leave irq");
    read(0, 32'h0, "R9 control read zero");
    read(6, 32'h0, "R9 control read zero core 3");

    // R8: destination out of range
    send(1, 16'd4, 16'hAAAA);
    send(1, 16'hFFFF, 16'h5555);
    check_irq("R8 bad dest ignored irq");
    read_sts(1, "R8 bad dest ignored status");
    for (int c = 0; c < NC; c++) read_sts(c, "R8 all status unchanged");

    // R7: clear keeps fields
    clear(2, 32'hA5A5_5A5A);
    check_irq("R7 clear drops irq 2");
    read_sts(2, "R7 fields kept after clear");
    clear(1, 32'h0);
    check_irq("R7 clear of idle core");

    // R2: self send, then re-raise cleared core
    send(0, 16'd0, 16'hC0DE);
    send(1, 16'd2, 16'h00FF);
    check_irq("R2 self send and re-raise");
    read_sts(2, "R3 re-raised status");
    read_sts(0, "R3 self status");

    for (int c = 0; c < NC; c++) clear(c, 32'(c) * 32'h1111_1111);
    check_irq("R7 all cleared");
    for (int c = 0; c < NC; c++) read_sts(c, "R7 final status");

    repeat (3) @(negedge clk);
    if (q.size() != 0) check(1'b0, "R9 reads not answered", 32'(q.size()), 32'd0);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule